// File: doc/BRIEF.md
# Firmware ROM/RAM overlay pager

This block decodes the memory window that holds an adapter's firmware. The decode space is 16 KB wide and its lower 8 KB is populated. In the lowest 6 KB the fixed firmware ROM always answers. The 2 KB slot directly above that is an overlay. It shows either the top 2 KB of the ROM or a private scratch RAM, which firmware uses to keep its settings. Reads in the unpopulated upper half of the decode return all ones.

A single I/O paging port picks which store the overlay shows. The data written to the port does not matter; only the direction of the access does. Any read of the port brings the ROM back and reports the previous selection. Any write selects the scratch RAM. Memory writes land only in the overlay slot, and only while the RAM is selected. After reset, the scratch RAM reads as a copy of the top 2 KB of the ROM until a location is overwritten.

The ROM image is a computed constant. Memory reads and port reads both give their data one clock after the strobe, and the output holds until the next read.

Top module: `fw_overlay_pager`

## Requirements
- R1: A memory read at an offset in 0x0000 to 0x17FF returns the ROM byte for that offset, whatever the page state. The ROM byte at offset a (13 bits) is a[7:0] XOR {a[12:8], a[12:10]} XOR 0x5A.
- R2: A memory read at 0x1800 to 0x1FFF returns the ROM byte while the ROM is selected, and the scratch RAM byte while the RAM is selected. The RAM index is offset bits 10..0.
- R3: A memory read at any offset with bit 13 set (0x2000 to 0x3FFF) returns 0xFF.
- R4: A memory write is ignored outside 0x1800 to 0x1FFF, and also inside that range while the ROM is selected.
- R5: A read of the paging port selects the ROM. One cycle later the port readback is 0x80 if the ROM was already selected, or 0x00 if the RAM was selected.
- R6: A write to the paging port selects the RAM, whatever the data. If the port is read and written in the same cycle, the RAM ends up selected and the readback still reports the prior state.
- R7: After reset the ROM is selected, and both the memory and port readbacks are 0x00.
- R8: After every reset, each scratch RAM location reads as the ROM byte at the same overlay offset until it is written.
- R9: Memory and port read data appear exactly one cycle after the strobe and hold until the next read of the same kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mem_off | input | 14 | Byte offset inside the 16 KB decode |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| mem_wdata | input | 8 | Memory write data |
| mem_rdata | output | 8 | Memory read data, one cycle after mem_rd |
| pg_rd | input | 1 | Paging port read strobe |
| pg_wr | input | 1 | Paging port write strobe |
| pg_rdata | output | 8 | Paging port readback, one cycle after pg_rd |

## Verification
The hardest state to reach is one where the ROM is selected again but the RAM holds a mix of overwritten and untouched bytes. A stale ROM copy and a real write can only be told apart after a further round trip through the paging port. The stimulus does this in order: it writes while the ROM is selected, selects the RAM, writes some locations, and returns to the ROM with a port read. It then selects the RAM once more and reads both written and unwritten locations. A reset in the middle of this shows that the untouched copy comes back.

// File: rtl/fw_overlay_pkg.sv
package fw_overlay_pkg;
  localparam int OFF_W    = 14;
  localparam int DATA_W   = 8;
  localparam int RAM_AW   = 11;
  localparam int RAM_DEPTH = 1 << RAM_AW;
  localparam logic [OFF_W-1:0] OVL_LO = 14'h1800;
  localparam logic [OFF_W-1:0] OPEN_LO = 14'h2000;
  localparam logic [DATA_W-1:0] OPEN_BYTE = 8'hFF;
  localparam logic [DATA_W-1:0] ROM_TAG = 8'h80;

  typedef enum logic [1:0] {REG_FIXED, REG_OVL, REG_OPEN} region_e;

  function automatic region_e region_of(input logic [OFF_W-1:0] off);
    if (off >= OPEN_LO)     return REG_OPEN;
    else if (off >= OVL_LO) return REG_OVL;
    else                    return REG_FIXED;
  endfunction

  function automatic logic [DATA_W-1:0] rom_byte(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], a[12:10]} ^ 8'h5A;
  endfunction
endpackage

// File: rtl/fw_rom.sv
module fw_rom
  import fw_overlay_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [12:0]       addr,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= rom_byte(addr);
  end
endmodule

// File: rtl/scratch_ram.sv
module scratch_ram
  import fw_overlay_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [RAM_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  output logic              q_written
);
  logic [DATA_W-1:0]    mem [RAM_DEPTH];
  logic [RAM_DEPTH-1:0] written;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) written <= '0;
    else if (we) written[addr] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q         <= '0;
      q_written <= 1'b0;
    end else if (re) begin
      q         <= mem[addr];
      q_written <= written[addr];
    end
  end
endmodule

// File: rtl/page_ctl.sv
module page_ctl
  import fw_overlay_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_rd,
  input  logic              pg_wr,
  output logic              rom_sel,
  output logic [DATA_W-1:0] pg_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rom_sel <= 1'b1;
    else if (pg_wr) rom_sel <= 1'b0;
    else if (pg_rd) rom_sel <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pg_rdata <= '0;
    else if (pg_rd) pg_rdata <= rom_sel ? ROM_TAG : '0;
  end
endmodule

// File: rtl/fw_overlay_pager.sv
module fw_overlay_pager
  import fw_overlay_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  mem_off,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata,
  input  logic              pg_rd,
  input  logic              pg_wr,
  output logic [DATA_W-1:0] pg_rdata
);
  region_e           cur_region;
  logic              rom_sel;
  logic              ram_we;
  logic              ram_pick;
  logic              open_q;
  logic              ram_pick_q;
  logic [DATA_W-1:0] rom_q;
  logic [DATA_W-1:0] ram_q;
  logic              ram_q_written;

  assign cur_region = region_of(mem_off);
  assign ram_we     = mem_wr && (cur_region == REG_OVL) && !rom_sel;
  assign ram_pick   = (cur_region == REG_OVL) && !rom_sel;

  page_ctl u_pg (
    .clk(clk), .rst_n(rst_n), .pg_rd(pg_rd), .pg_wr(pg_wr),
    .rom_sel(rom_sel), .pg_rdata(pg_rdata)
  );

  fw_rom u_rom (
    .clk(clk), .rst_n(rst_n), .re(mem_rd), .addr(mem_off[12:0]), .q(rom_q)
  );

  scratch_ram u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .re(mem_rd),
    .addr(mem_off[RAM_AW-1:0]), .wdata(mem_wdata),
    .q(ram_q), .q_written(ram_q_written)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      ram_pick_q <= 1'b0;
    end else if (mem_rd) begin
      open_q     <= (cur_region == REG_OPEN);
      ram_pick_q <= ram_pick;
    end
  end

  always_comb begin
    if (open_q)                         mem_rdata = OPEN_BYTE;
    else if (ram_pick_q && ram_q_written) mem_rdata = ram_q;
    else                                mem_rdata = rom_q;
  end
endmodule

// File: rtl/fw_overlay_pager_chk.sv
module fw_overlay_pager_chk
  import fw_overlay_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [OFF_W-1:0]  mem_off,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              pg_rd,
  input logic              pg_wr,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] pg_rdata,
  input logic              rom_sel,
  input logic              ram_we
);
  // R3
  open_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_off[13]) |=> (mem_rdata == 8'hFF));
  // R5
  port_read_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_rd && !pg_wr) |=> rom_sel);
  // R5
  port_read_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_rd |=> (pg_rdata == ($past(rom_sel) ? 8'h80 : 8'h00)));
  // R6
  port_write_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_wr |=> !rom_sel);
  // R4
  write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (mem_wr && !rom_sel && !mem_off[13] && (mem_off[12:11] == 2'b11)));
  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd && !mem_wr) |=> $stable(mem_rdata));
  // R9
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_rd && !pg_wr) |=> ($stable(pg_rdata) && $stable(rom_sel)));
endmodule

bind fw_overlay_pager fw_overlay_pager_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_off(mem_off), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .pg_rd(pg_rd), .pg_wr(pg_wr), .mem_rdata(mem_rdata),
  .pg_rdata(pg_rdata), .rom_sel(rom_sel), .ram_we(ram_we)
);

// File: tb/sim_fw_overlay_pager.sv
module sim_fw_overlay_pager;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] MR = 2'd0, MW = 2'd1, PR = 2'd2, PW = 2'd3;
  localparam logic [8:0] USE_ROM = 9'h100;
  localparam int NV = 22;
  // {op, offset, data, expected}; expected 9'h100 = ROM byte for the offset
  localparam logic [32:0] VEC [NV] = '{
    {MR, 14'h0010, 8'h00, 9'h100},  // R1
    {MR, 14'h1800, 8'h00, 9'h100},  // R2 rom selected
    {MW, 14'h1800, 8'h11, 9'h000},  // R4 ignored, rom selected
    {PW, 14'h0000, 8'h00, 9'h000},  // R6
    {MR, 14'h1800, 8'h00, 9'h100},  // R8 copy
    {MW, 14'h1800, 8'h11, 9'h000},
    {MR, 14'h1800, 8'h00, 9'h011},  // R2 ram
    {MW, 14'h0100, 8'h22, 9'h000},  // R4 fixed area
    {MR, 14'h0100, 8'h00, 9'h100},  // R1/R4
    {MW, 14'h2005, 8'h33, 9'h000},  // R4 open area
    {MR, 14'h2005, 8'h00, 9'h0FF},  // R3
    {MR, 14'h1FFF, 8'h00, 9'h100},  // R8
    {MW, 14'h1FFF, 8'h44, 9'h000},
    {MR, 14'h1FFF, 8'h00, 9'h044},  // R2
    {MR, 14'h17FF, 8'h00, 9'h100},  // R1 boundary
    {PR, 14'h0000, 8'h00, 9'h000},  // R5 was ram
    {MR, 14'h1800, 8'h00, 9'h100},  // R2 rom again
    {PR, 14'h0000, 8'h00, 9'h080},  // R5 was rom
    {PW, 14'h0000, 8'hA7, 9'h000},  // R6 data ignored
    {MR, 14'h1800, 8'h00, 9'h011},  // R2 persisted
    {MR, 14'h3FFF, 8'h00, 9'h0FF},  // R3
    {MR, 14'h1C00, 8'h00, 9'h100}   // R8 untouched
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [13:0] mem_off = '0;
  logic mem_rd = 0, mem_wr = 0, pg_rd = 0, pg_wr = 0;
  logic [7:0] mem_wdata = '0;
  logic [7:0] mem_rdata, pg_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fw_overlay_pager u0 (
    .clk(clk), .rst_n(rst_n), .mem_off(mem_off), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pg_rd(pg_rd), .pg_wr(pg_wr), .pg_rdata(pg_rdata)
  );

  function automatic logic [7:0] ref_rom(input int off);
    int b;
    b = (off >> 8) & 31;
    return 8'(((off & 255) ^ ((b << 3) | (b >> 2)) ^ 'h5A) & 255);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [13:0] off, input logic [7:0] d);
    @(negedge clk);
    mem_off = off; mem_wdata = d;
    mem_rd = (op == MR); mem_wr = (op == MW);
    pg_rd = (op == PR);  pg_wr = (op == PW);
    @(negedge clk);
    mem_rd = 0; mem_wr = 0; pg_rd = 0; pg_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    logic [7:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R7 mem readback", mem_rdata, 8'h00);
    check("R7 port readback", pg_rdata, 8'h00);
    do_op(MR, 14'h1A00, 8'h00);
    check("R7 rom selected", mem_rdata, ref_rom('h1A00));

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [13:0] off; logic [7:0] d; logic [8:0] e;
      {op, off, d, e} = VEC[i];
      do_op(op, off, d);
      exp = (e == USE_ROM) ? ref_rom(int'(off)) : e[7:0];
      if (op == MR) check("R1/R2/R3/R4/R8 table mem read", mem_rdata, exp);
      if (op == PR) check("R5 table port read", pg_rdata, exp);
    end

    // R9: readback holds across idle cycles and port traffic
    exp = mem_rdata;
    repeat (3) @(negedge clk);
    do_op(PR, 14'h0, 8'h0);
    check("R9 mem data holds", mem_rdata, exp);

    // R9: one-cycle latency, sampled right after the first edge
    @(negedge clk);
    mem_off = 14'h0042; mem_rd = 1;
    @(negedge clk);
    mem_rd = 0;
    check("R9 latency", mem_rdata, ref_rom('h0042));

    // R6: simultaneous port read and write while rom selected
    @(negedge clk);
    pg_rd = 1; pg_wr = 1;
    @(negedge clk);
    pg_rd = 0; pg_wr = 0;
    check("R6 both strobes readback", pg_rdata, 8'h80);
    do_op(MR, 14'h1800, 8'h0);
    check("R6 both strobes selects ram", mem_rdata, 8'h11);

    // R8: reset restores the rom copy and rom selection
    do_reset();
    check("R7 readback after reset", mem_rdata, 8'h00);
    do_op(PW, 14'h0, 8'h0);
    do_op(MR, 14'h1800, 8'h0);
    check("R8 copy after reset", mem_rdata, ref_rom('h1800));
    do_op(MR, 14'h1FFF, 8'h0);
    check("R8 copy after reset top", mem_rdata, ref_rom('h1FFF));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule